// File: doc/BRIEF.md
# Multi-Size Integer DCT Matrix Engine

This block evaluates a one-dimensional integer discrete cosine transform as a matrix-vector product on a vector of signed residual samples. Each input lane drives one shift-and-add multiplier per output row. Each multiplier's constant is picked by the current size mode and by the output index. The products for one output are summed in a binary signed adder tree with log2(N) levels.

One array of multipliers and adder trees serves all transform sizes. A mode code selects the sizes. In the full mode the whole vector is transformed as one N-point block. Each higher mode code halves the transform length and splits the input into independent segments that are transformed side by side. Each sub-transform writes its results into the output positions that match its input segment. The coefficients are the usual integer cosine values scaled by 64, and each smaller matrix is a row subset of the larger one. Results keep full precision. They are captured in an output register whenever the input strobe is high, so the block takes one vector per cycle and returns it one cycle later.

Top module: `dct_multi_engine`

## Requirements
- R1: While reset is low, and after it is released, `out_valid` is 0 and every output lane is 0 until the first strobed vector arrives.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high at the clock edge.
- R3: While `in_valid` is low, `y_out` keeps its previous value, whatever `x_in` and `mode` do.
- R4: With `mode` = 0, output lane k equals the sum over n of C8[k][n]·x[n]. C8 is the 8-point integer DCT matrix scaled by 64: row 0 is all 64, row 2 starts 83, 36, and row 1 starts 89, 75, 50, 18.
- R5: With `mode` = 1, lanes 0..3 hold the 4-point transform of samples 0..3 and lanes 4..7 hold the 4-point transform of samples 4..7. The 4-point row r is row 2r of C8, restricted to its first four columns.
- R6: With `mode` = 2, each pair of lanes 2j, 2j+1 holds the 2-point transform of samples 2j, 2j+1, with rows (64, 64) and (64, −64).
- R7: In a split mode, a sub-transform's outputs do not depend on samples outside its own segment.
- R8: A `mode` value above the last valid code (2 for N = 8) selects the 2-point mode.
- R9: Inputs are 16-bit two's complement, and each output lane is 27 bits (16 + 8 + log2 N) two's complement with no rounding. Extreme inputs of −32768 or 32767 in every lane never overflow.
- R10: An all-zero input vector gives an all-zero output in every mode.
- R11: Each multiplier output equals the exact signed product of its sample and its coefficient.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe that captures the current vector's result |
| mode | input | 2 | Size code: 0 full length, each step halves the length |
| x_in | input | N*16 | Sample vector, lane n at bits [16n+15:16n] |
| out_valid | output | 1 | Result register holds a new vector |
| y_out | output | N*27 | Result vector, lane k at bits [27k+26:27k] |

## Verification
The assertions assume that `x_in` and `mode` hold known values whenever `in_valid` is high, and that the strobe is the only thing that qualifies data. The product check in each multiplier is skipped while its sample is unknown. The bench drives every input on the falling edge, so both fields are settled well before the capturing edge. It sweeps all four mode codes with impulses at every lane, extreme-value fills, alternating-sign fills and pseudo-random vectors.

// File: rtl/dct_pkg.sv
package dct_pkg;

  // Magnitude of 64*sqrt(2)*cos(a*pi/64)-style integer constants, a = 0..32
  function automatic int base_mag(input int a);
    case (a)
      0: return 64;  1: return 90;  2: return 90;  3: return 90;
      4: return 89;  5: return 88;  6: return 87;  7: return 85;
      8: return 83;  9: return 82;  10: return 80; 11: return 78;
      12: return 75; 13: return 73; 14: return 70; 15: return 67;
      16: return 64; 17: return 61; 18: return 57; 19: return 54;
      20: return 50; 21: return 46; 22: return 43; 23: return 38;
      24: return 36; 25: return 31; 26: return 25; 27: return 22;
      28: return 18; 29: return 13; 30: return 9;  31: return 4;
      default: return 0;
    endcase
  endfunction

  // Entry (row, col) of the len-point matrix, len a power of two up to 32
  function automatic int mat_coef(input int len, input int row, input int col);
    int a;
    a = (row * (2 * col + 1) * (32 / len)) % 128;
    if (a <= 32)      return  base_mag(a);
    else if (a <= 64) return -base_mag(64 - a);
    else if (a <= 96) return -base_mag(a - 64);
    else              return  base_mag(128 - a);
  endfunction

  // Coefficient linking input n to output k when the n_pts engine runs in size code m
  function automatic int seg_coef(input int n_pts, input int m, input int k, input int n);
    int len;
    len = n_pts >> m;
    if ((k / len) != (n / len)) return 0;
    return mat_coef(len, k % len, n % len);
  endfunction

  // Signed product of a sample and a coefficient, written as shift-and-add
  function automatic longint shift_add(input longint x, input int c);
    longint acc;
    int mag;
    acc = 0;
    mag = (c < 0) ? -c : c;
    for (int b = 0; b < 8; b++)
      if (mag[b]) acc = acc + (x <<< b);
    return (c < 0) ? -acc : acc;
  endfunction

endpackage

// File: rtl/dct_coef_sel.sv
module dct_coef_sel #(
  parameter int N     = 8,
  parameter int MODES = 3,
  parameter int SEW   = 2,
  parameter int CW    = 8,
  parameter int K     = 0,
  parameter int IDX   = 0
) (
  input  logic [SEW-1:0]       mode_eff,
  output logic signed [CW-1:0] coef
);
  import dct_pkg::*;

  logic signed [CW-1:0] opts [MODES];

  for (genvar m = 0; m < MODES; m++) begin : g_opt
    localparam int CV = seg_coef(N, m, K, IDX);
    assign opts[m] = CW'(CV);
  end

  always_comb begin
    coef = '0;
    for (int m = 0; m < MODES; m++)
      if (int'(mode_eff) == m) coef = opts[m];
  end
endmodule

// File: rtl/dct_shift_add_mult.sv
module dct_shift_add_mult #(
  parameter int IW = 16,
  parameter int CW = 8,
  parameter int PW = IW + CW
) (
  input  logic signed [IW-1:0] x,
  input  logic signed [CW-1:0] coef,
  output logic signed [PW-1:0] prod
);
  logic [CW-1:0]        mag;
  logic                 neg;
  logic signed [PW-1:0] xe;
  logic signed [PW-1:0] part [CW];
  logic signed [PW-1:0] acc;

  assign neg = coef[CW-1];
  assign mag = neg ? CW'(-coef) : coef;
  assign xe  = PW'(x);

  for (genvar b = 0; b < CW; b++) begin : g_part
    assign part[b] = mag[b] ? (xe <<< b) : '0;
  end

  always_comb begin
    acc = '0;
    for (int b = 0; b < CW; b++) acc = acc + part[b];
  end

  assign prod = neg ? -acc : acc;

  // R11: shift-add result matches the exact signed product
  always_comb begin
    if (!$isunknown({x, coef}))
      a_r11_exact_product: assert (prod == PW'(x) * PW'(coef));
  end
endmodule

// File: rtl/dct_adder_tree.sv
module dct_adder_tree #(
  parameter int N  = 8,
  parameter int PW = 24,
  parameter int OW = 27
) (
  input  logic [N*PW-1:0]      terms,
  output logic signed [OW-1:0] total
);
  localparam int NODES = 2 * N - 1;

  logic signed [OW-1:0] node [NODES];

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign node[N-1+i] = OW'($signed(terms[i*PW +: PW]));
  end

  for (genvar i = 0; i < N - 1; i++) begin : g_sum
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  assign total = node[0];
endmodule

// File: rtl/dct_multi_engine.sv
module dct_multi_engine #(
  parameter int N   = 8,
  parameter int IW  = 16,
  parameter int CW  = 8,
  parameter int OW  = IW + 8 + $clog2(N),
  parameter int MW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [MW-1:0]   mode,
  input  logic [N*IW-1:0] x_in,
  output logic            out_valid,
  output logic [N*OW-1:0] y_out
);
  localparam int MODES = $clog2(N);
  localparam int SEW   = (MODES > 1) ? $clog2(MODES) : 1;
  localparam int PW    = IW + CW;
  localparam int LAST  = MODES - 1;

  logic [SEW-1:0]   mode_eff;
  logic [N*OW-1:0]  y_next;

  // R8: codes past the last one fall back to the shortest transform
  assign mode_eff = (int'(mode) > LAST) ? SEW'(LAST) : SEW'(mode);

  for (genvar k = 0; k < N; k++) begin : g_row
    logic [N*PW-1:0]      prods;
    logic signed [OW-1:0] row_sum;

    for (genvar n = 0; n < N; n++) begin : g_lane
      logic signed [CW-1:0] coef;
      logic signed [PW-1:0] prod;

      dct_coef_sel #(.N(N), .MODES(MODES), .SEW(SEW), .CW(CW), .K(k), .IDX(n))
        u_sel (.mode_eff(mode_eff), .coef(coef));

      dct_shift_add_mult #(.IW(IW), .CW(CW), .PW(PW))
        u_mult (.x(x_in[n*IW +: IW]), .coef(coef), .prod(prod));

      assign prods[n*PW +: PW] = prod;
    end

    dct_adder_tree #(.N(N), .PW(PW), .OW(OW))
      u_tree (.terms(prods), .total(row_sum));

    assign y_next[k*OW +: OW] = row_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      y_out     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) y_out <= y_next;
    end
  end

  // Named reference for the DC row: 64 times the plain sample sum
  logic signed [OW-1:0] dc_ref;
  always_comb begin
    dc_ref = '0;
    for (int n = 0; n < N; n++) dc_ref = dc_ref + OW'($signed(x_in[n*IW +: IW]));
    dc_ref = dc_ref <<< 6;
  end
  logic all_zero;
  assign all_zero = (x_in == '0);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(y_out));
  a_r4_dc_row: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_eff == '0) |=> ($signed(y_out[OW-1:0]) == $past(dc_ref)));
  a_r10_zero_in_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && all_zero) |=> (y_out == '0));
endmodule

// File: tb/dct_multi_engine_test.sv
module dct_multi_engine_test;
  localparam int N  = 8;
  localparam int IW = 16;
  localparam int OW = 27;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [1:0]      mode = '0;
  logic [N*IW-1:0] x_in = '0;
  logic            out_valid;
  logic [N*OW-1:0] y_out;

  int checks = 0;
  int errors = 0;
  int xv [N];
  int seed = 32'h5a17;

  // 8-point matrix, written out; smaller sizes are its even-row subsets
  int c8 [8][8] = '{
    '{64, 64, 64, 64, 64, 64, 64, 64},
    '{89, 75, 50, 18,-18,-50,-75,-89},
    '{83, 36,-36,-83,-83,-36, 36, 83},
    '{75,-18,-89,-50, 50, 89, 18,-75},
    '{64,-64,-64, 64, 64,-64,-64, 64},
    '{50,-89, 18, 75,-75,-18, 89,-50},
    '{36,-83, 83,-36,-36, 83,-83, 36},
    '{18,-50, 75,-89, 89,-75, 50,-18}};

  dct_multi_engine uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
                        .x_in(x_in), .out_valid(out_valid), .y_out(y_out));

  always #2 clk = ~clk;

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic longint ref_coef(int code, int k, int n);
    int len;
    len = (code >= 2) ? 2 : (8 >> code);
    if (k / len != n / len) return 0;
    return c8[(k % len) * (8 / len)][n % len];
  endfunction

  function automatic longint expect_lane(int code, int k);
    longint s = 0;
    for (int n = 0; n < N; n++) s += ref_coef(code, k, n) * xv[n];
    return s;
  endfunction

  function automatic longint got_lane(int k);
    return longint'($signed(y_out[k*OW +: OW]));
  endfunction

  task automatic check(string req, longint got, longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Drive xv with the given code, check the whole vector one cycle later
  task automatic run_vec(int code, string req);
    bit ok = 1;
    longint g = 0, e = 0;
    @(negedge clk);
    mode = 2'(code);
    for (int n = 0; n < N; n++) x_in[n*IW +: IW] = 16'(xv[n]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " out_valid (R2)"}, longint'(out_valid), 1);
    for (int k = 0; k < N; k++)
      if (ok && got_lane(k) != expect_lane(code, k)) begin
        ok = 0; g = got_lane(k); e = expect_lane(code, k);
      end
    check(req, g, e);
  endtask

  function automatic string req_of(int code);
    case (code)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 out_valid in reset", longint'(out_valid), 0);
    check("R1 y_out in reset", longint'(y_out != '0), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after release", longint'(out_valid), 0);
    check("R1 y_out after release", longint'(y_out != '0), 0);

    for (int code = 0; code < 4; code++) begin
      // R10: zero vector
      for (int n = 0; n < N; n++) xv[n] = 0;
      run_vec(code, "R10 zero input");
      // impulses at every lane
      for (int p = 0; p < N; p++) begin
        for (int n = 0; n < N; n++) xv[n] = (n == p) ? ((p % 2) ? -1000 : 777) : 0;
        run_vec(code, req_of(code));
      end
      // R9: extreme fills
      for (int n = 0; n < N; n++) xv[n] = -32768;
      run_vec(code, "R9 all minimum");
      for (int n = 0; n < N; n++) xv[n] = 32767;
      run_vec(code, "R9 all maximum");
      for (int n = 0; n < N; n++) xv[n] = (n % 2) ? -32768 : 32767;
      run_vec(code, "R9 alternating extremes");
      for (int n = 0; n < N; n++) xv[n] = (n < 4) ? 32767 : -32768;
      run_vec(code, "R9 split extremes");
      // random vectors
      for (int t = 0; t < 40; t++) begin
        for (int n = 0; n < N; n++) xv[n] = int'($signed(16'($urandom(seed))));
        seed = seed + 1;
        run_vec(code, req_of(code));
      end
    end

    // R7: segment isolation in the 4-point mode: change the upper half only
    begin
      longint lower [4];
      for (int n = 0; n < N; n++) xv[n] = 1000 * (n + 1) - 4321;
      run_vec(1, "R5");
      for (int k = 0; k < 4; k++) lower[k] = got_lane(k);
      for (int n = 4; n < N; n++) xv[n] = -30000 + n;
      run_vec(1, "R5");
      for (int k = 0; k < 4; k++) check("R7 lower segment unchanged", got_lane(k), lower[k]);
    end

    // R3: with the strobe low, input and mode changes leave y_out alone
    begin
      logic [N*OW-1:0] held;
      held = y_out;
      @(negedge clk);
      mode = 2'd2;
      x_in = {N{16'h7abc}};
      @(negedge clk);
      @(negedge clk);
      check("R3 y_out held", longint'(y_out != held), 0);
      check("R2 out_valid low when idle", longint'(out_valid), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule